// File: doc/BRIEF.md
# Masked Sliding-Window Sequence Detector

This block watches a serial bit stream, one bit per clock, and raises a single flag whenever the most recent twelve bits form a fixed pattern. Eleven past bits are held in a shift register. The bit on the input this cycle fills the twelfth position, so the flag reflects the window that ends at the present bit, with no clock of delay.

The pattern is given as a value and a care mask. A cleared care bit makes that position a don't-care. A second value and mask pair supplies an alternative for the whole window. The block reports a match when either rule holds. With the default parameters the two rules agree everywhere except in the middle four positions, which lets that group take one of two masked shapes. After a synchronous reset the flag stays low until enough real bits have arrived to fill the history.

Top module: `masked_seq_detector`

## Requirements
- R1: On every clock edge with reset low, the stored history moves one place older and the bit on `x_i` becomes the newest stored bit, x(t-1) for the following cycle.
- R2: While `rst_i` is high, `z_o` is 0. A high `rst_i` at a clock edge clears the stored history to zeros.
- R3: After reset is released, `z_o` stays 0 until eleven bits have been shifted in. The first cycle that may flag a match is the one in which the twelfth bit is on `x_i`.
- R4: Newest group: a match needs x(t)=1, x(t-1)=1 and x(t-3)=0. The value of x(t-2) has no effect on `z_o`.
- R5: Middle group, first shape: x(t-4)=1, x(t-6)=1, x(t-7)=0, with x(t-5) ignored.
- R6: Middle group, second shape: x(t-4)=0 and x(t-6)=0, with x(t-5) and x(t-7) ignored. A window matches if its middle group fits either shape.
- R7: Oldest group: x(t-8)=1, x(t-9)=0, x(t-10)=0, x(t-11)=1, with every position compared.
- R8: `z_o` depends combinationally on `x_i`. Changing `x_i` within a cycle changes `z_o` in that same cycle, with no clock edge in between.
- R9: With x(t) down to x(t-11) equal to 110010101001, `z_o` is 1. With 101001011001, `z_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| x_i | input | 1 | Serial data bit, x(t) |
| z_o | output | 1 | High when the window x(t)..x(t-11) matches |

## Verification
The bench builds the block with its default parameters: a twelve-bit window with both middle-group shapes enabled. This makes the eleven-bit fill boundary, every care and don't-care position, and both alternative shapes reachable with short directed windows. Every cared position is flipped one at a time under both shapes, and every don't-care is toggled. A long pseudo-random stream seeded with embedded patterns then exercises overlapping and back-to-back matches against a queue-based model.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

   // Selects whether the alternative pattern takes part in matching.
   typedef enum logic [0:0] {
      MATCH_PRIMARY_ONLY = 1'b0,
      MATCH_EITHER       = 1'b1
   } alt_mode_e;

   // Upper bound on the window length accepted by the block.
   localparam int unsigned SEQDET_MAX_WIN = 64;

   // Count of bits needed to hold a value up to n inclusive.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/seqdet_hist.sv
// Serial history: stage 0 holds x(t-1), stage HIST_LEN-1 holds the oldest bit.
module seqdet_hist #(
   parameter int unsigned HIST_LEN = 11
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                x_i,
   output logic [HIST_LEN-1:0] hist_o
);

   logic [HIST_LEN-1:0] stage_q;

   genvar g;
   generate
      for (g = 0; g < HIST_LEN; g++) begin : g_stage
         logic feed;
         if (g == 0) begin : g_head
            assign feed = x_i;
         end else begin : g_body
            assign feed = stage_q[g-1];
         end
         always_ff @(posedge clk_i) begin
            if (rst_i) stage_q[g] <= 1'b0;
            else       stage_q[g] <= feed;
         end
      end
   endgenerate

   assign hist_o = stage_q;

endmodule

// File: rtl/seqdet_fill.sv
// Saturating count of shifts since reset; flags when the history is full.
module seqdet_fill #(
   parameter int unsigned HIST_LEN = 11
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic filled_o
);
   import seqdet_pkg::*;

   localparam int unsigned CW = cnt_width(HIST_LEN);
   localparam logic [CW-1:0] FULL = CW'(HIST_LEN);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)              cnt_q <= '0;
      else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
   end

   assign filled_o = (cnt_q == FULL);

endmodule

// File: rtl/seqdet_match.sv
// Masked window compare against one or two value/care rules.
module seqdet_match
   import seqdet_pkg::*;
#(
   parameter int unsigned          WIN_LEN  = 12,
   parameter logic [WIN_LEN-1:0]   PRI_VAL  = '0,
   parameter logic [WIN_LEN-1:0]   PRI_CARE = '0,
   parameter alt_mode_e            ALT_MODE = MATCH_EITHER,
   parameter logic [WIN_LEN-1:0]   ALT_VAL  = '0,
   parameter logic [WIN_LEN-1:0]   ALT_CARE = '0
) (
   input  logic [WIN_LEN-1:0] win_i,
   output logic               hit_o
);

   logic [WIN_LEN-1:0] pri_ok;
   logic               pri_hit;

   genvar k;
   generate
      for (k = 0; k < WIN_LEN; k++) begin : g_pri_bit
         if (PRI_CARE[k]) begin : g_cmp
            assign pri_ok[k] = (win_i[k] == PRI_VAL[k]);
         end else begin : g_dc
            assign pri_ok[k] = 1'b1;
         end
      end
   endgenerate

   assign pri_hit = &pri_ok;

   generate
      if (ALT_MODE == MATCH_EITHER) begin : g_alt
         logic [WIN_LEN-1:0] alt_ok;
         for (k = 0; k < WIN_LEN; k++) begin : g_alt_bit
            if (ALT_CARE[k]) begin : g_cmp
               assign alt_ok[k] = (win_i[k] == ALT_VAL[k]);
            end else begin : g_dc
               assign alt_ok[k] = 1'b1;
            end
         end
         assign hit_o = pri_hit | (&alt_ok);
      end else begin : g_single
         assign hit_o = pri_hit;
      end
   endgenerate

endmodule

// File: rtl/masked_seq_detector.sv
// Window bit k is x(t-k): bit 0 is the live input, bits 1.. come from history.
module masked_seq_detector
   import seqdet_pkg::*;
#(
   parameter int unsigned        WIN_LEN  = 12,
   parameter logic [WIN_LEN-1:0] PRI_VAL  = 12'h953,
   parameter logic [WIN_LEN-1:0] PRI_CARE = 12'hFDB,
   parameter alt_mode_e          ALT_MODE = MATCH_EITHER,
   parameter logic [WIN_LEN-1:0] ALT_VAL  = 12'h903,
   parameter logic [WIN_LEN-1:0] ALT_CARE = 12'hF5B
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic x_i,
   output logic z_o
);

   localparam int unsigned HIST_LEN = WIN_LEN - 1;

   generate
      if (WIN_LEN < 2 || WIN_LEN > SEQDET_MAX_WIN) begin : g_bad_len
         $error("masked_seq_detector: WIN_LEN out of range");
      end
      if ((PRI_VAL & ~PRI_CARE) != '0) begin : g_bad_pri
         $error("masked_seq_detector: primary value set under a don't-care");
      end
      if (ALT_MODE == MATCH_EITHER && (ALT_VAL & ~ALT_CARE) != '0) begin : g_bad_alt
         $error("masked_seq_detector: alternative value set under a don't-care");
      end
   endgenerate

   logic [HIST_LEN-1:0] hist_q;
   logic [WIN_LEN-1:0]  window;
   logic                hit;
   logic                filled;

   seqdet_hist #(.HIST_LEN(HIST_LEN)) u_hist (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .x_i    (x_i),
      .hist_o (hist_q)
   );

   seqdet_fill #(.HIST_LEN(HIST_LEN)) u_fill (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .filled_o (filled)
   );

   assign window = {hist_q, x_i};

   seqdet_match #(
      .WIN_LEN  (WIN_LEN),
      .PRI_VAL  (PRI_VAL),
      .PRI_CARE (PRI_CARE),
      .ALT_MODE (ALT_MODE),
      .ALT_VAL  (ALT_VAL),
      .ALT_CARE (ALT_CARE)
   ) u_match (
      .win_i (window),
      .hit_o (hit)
   );

   assign z_o = hit & filled & ~rst_i;

endmodule

// File: rtl/seqdet_chk.sv
module seqdet_chk
   import seqdet_pkg::*;
#(
   parameter int unsigned        WIN_LEN  = 12,
   parameter logic [WIN_LEN-1:0] PRI_VAL  = '0,
   parameter logic [WIN_LEN-1:0] PRI_CARE = '0,
   parameter alt_mode_e          ALT_MODE = MATCH_EITHER,
   parameter logic [WIN_LEN-1:0] ALT_VAL  = '0,
   parameter logic [WIN_LEN-1:0] ALT_CARE = '0
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic               x_i,
   input logic               z_o,
   input logic [WIN_LEN-2:0] hist_i
);

   localparam int unsigned HIST_LEN = WIN_LEN - 1;
   localparam int unsigned CW = cnt_width(HIST_LEN);
   localparam logic [CW-1:0] FULL = CW'(HIST_LEN);

   // A position fixed to the same value by every active rule.
   localparam bit NEW_FIXED = PRI_CARE[0] &&
      (ALT_MODE == MATCH_PRIMARY_ONLY || (ALT_CARE[0] && ALT_VAL[0] == PRI_VAL[0]));
   localparam bit OLD_FIXED = PRI_CARE[WIN_LEN-1] &&
      (ALT_MODE == MATCH_PRIMARY_ONLY ||
       (ALT_CARE[WIN_LEN-1] && ALT_VAL[WIN_LEN-1] == PRI_VAL[WIN_LEN-1]));

   logic [CW-1:0] since_q;
   always_ff @(posedge clk_i) begin
      if (rst_i)               since_q <= '0;
      else if (since_q != FULL) since_q <= since_q + 1'b1;
   end

   // R1: newest stored bit is last cycle's input
   p_shift_head_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (hist_i[0] == $past(x_i)));

   // R1: oldest stage takes the previous content of its neighbour
   p_shift_tail_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (hist_i[HIST_LEN-1] == $past(hist_i[HIST_LEN-2])));

   // R2: history is zero right after a reset edge
   p_reset_clear_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (hist_i == '0));

   // R3: no flag before the history has been filled
   p_fill_quiet_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (since_q != FULL) |-> !z_o);

   // R4: a flag implies the live bit matches
   p_newest_bit_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (NEW_FIXED && z_o) |-> (x_i == PRI_VAL[0]));

   // R7: a flag implies the oldest stored bit matches
   p_oldest_bit_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (OLD_FIXED && z_o) |-> (hist_i[HIST_LEN-1] == PRI_VAL[WIN_LEN-1]));

endmodule

bind masked_seq_detector seqdet_chk #(
   .WIN_LEN  (WIN_LEN),
   .PRI_VAL  (PRI_VAL),
   .PRI_CARE (PRI_CARE),
   .ALT_MODE (ALT_MODE),
   .ALT_VAL  (ALT_VAL),
   .ALT_CARE (ALT_CARE)
) u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .x_i    (x_i),
   .z_o    (z_o),
   .hist_i (hist_q)
);

// File: tb/masked_seq_detector_test.sv
`timescale 1ns/1ps
module masked_seq_detector_test;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x   = 1'b0;
   logic z;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   bit hq[$];     // hq[0] is x(t-1)
   int since = 0; // shifts since reset

   always #2.5 clk = ~clk;

   masked_seq_detector uut (
      .clk_i (clk),
      .rst_i (rst),
      .x_i   (x),
      .z_o   (z)
   );

   // Expected flag from R4..R7, w[k] = x(t-k).
   function automatic bit ref_match(input bit w[12]);
      bit newest, mid_a, mid_b, oldest;
      newest = w[0] && w[1] && !w[3];                    // R4
      mid_a  = w[4] && w[6] && !w[7];                    // R5
      mid_b  = !w[4] && !w[6];                           // R6
      oldest = w[8] && !w[9] && !w[10] && w[11];         // R7
      return newest && (mid_a || mid_b) && oldest;
   endfunction

   function automatic bit expected(input bit xb, input bit rb);
      bit w[12];
      if (rb || since < 11) return 1'b0;                 // R2, R3
      w[0] = xb;
      for (int k = 1; k < 12; k++) w[k] = hq[k-1];
      return ref_match(w);
   endfunction

   task automatic check(input string tag, input bit xb, input bit rb);
      bit e;
      e = expected(xb, rb);
      vectors++;
      if (z !== e) begin
         miscompares++;
         $display("FAIL %s: z=%b expected %b (cycle %0d)", tag, z, e, vectors);
      end
   endtask

   task automatic advance(input bit xb, input bit rb);
      if (rb) begin
         hq.delete();
         since = 0;
      end else begin
         hq.push_front(xb);
         if (hq.size() > 11) void'(hq.pop_back());
         since++;
      end
   endtask

   // Drive one bit away from the rising edge, check, then let the edge happen.
   task automatic step(input bit xb, input bit rb, input string tag);
      @(negedge clk);
      x = xb; rst = rb;
      #1;
      check(tag, xb, rb);
      advance(xb, rb);
   endtask

   // w[k] = x(t-k); sent oldest first, the last bit completes the window.
   task automatic send_win(input logic [11:0] w, input string tag);
      for (int k = 11; k >= 0; k--) step(w[k], 1'b0, tag);
   endtask

   task automatic do_reset(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b1, "R2");
   endtask

   localparam logic [11:0] BASE_A = 12'h953;  // 1,1,0,0 | 1,0,1,0 | 1,0,0,1
   localparam logic [11:0] BASE_B = 12'h903;  // 1,1,0,0 | 0,0,0,0 | 1,0,0,1

   initial begin
      // R2: flag low across reset
      do_reset(4);

      // R3: full pattern straight after reset flags exactly on its twelfth bit
      send_win(BASE_A, "R3");

      // R3: history loaded with a prefix, then reset; next bits cannot match early
      send_win(BASE_A, "R1");
      do_reset(1);
      for (int i = 0; i < 11; i++) step(1'b1, 1'b0, "R3");

      // R9: the two worked windows
      send_win(12'h953, "R9");
      send_win(12'h9A5, "R9");

      // R4, R5, R6: don't-care positions toggled
      send_win(BASE_A | 12'h004, "R4");
      send_win(BASE_A | 12'h020, "R5");
      send_win(BASE_B | 12'h020, "R6");
      send_win(BASE_B | 12'h080, "R6");
      send_win(BASE_B | 12'h0A4, "R6");

      // R4..R7: each position flipped under both shapes
      for (int k = 0; k < 12; k++) begin
         send_win(BASE_A ^ (12'h001 << k), "R5");
         send_win(BASE_B ^ (12'h001 << k), "R6");
         send_win(BASE_A ^ (12'h001 << k), "R7");
      end

      // R8: same-cycle response to the live bit
      send_win(BASE_A, "R8");
      for (int k = 11; k >= 1; k--) step(BASE_A[k], 1'b0, "R8");
      @(negedge clk);
      x = 1'b0; #1; check("R8", 1'b0, 1'b0);
      x = 1'b1; #1; check("R8", 1'b1, 1'b0);
      x = 1'b0; #1; check("R8", 1'b0, 1'b0);
      advance(1'b0, 1'b0);

      // R1, R9: long stream with embedded and corrupted patterns
      for (int n = 0; n < 600; n++) begin
         int sel;
         sel = $urandom_range(0, 3);
         if (sel == 0) begin
            for (int i = 0; i < 5; i++) step(1'($urandom_range(0, 1)), 1'b0, "R1");
         end else begin
            logic [11:0] w;
            w = (sel == 1) ? BASE_A : BASE_B;
            w = w | (12'($urandom) & ((sel == 1) ? 12'h024 : 12'h0A4));
            if ($urandom_range(0, 1) == 1) w = w ^ (12'h001 << $urandom_range(0, 11));
            send_win(w, "R9");
         end
         if (n == 300) do_reset(2);
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule